// File: doc/BRIEF.md
# External Bus Chip-Select Timing Sequencer

This block shapes the control strobes of one external memory access at a time. It runs on the external memory clock and serves a fixed number of chip-select areas (four by default). For each access it issues an address strobe, the chip-select line of the addressed area, a single-cycle read or write strobe, a matching DMA-acknowledge line and a done pulse. All outputs are active low except `done` and `req_ready`.

Each area has a three-bit timing setting. One bit delays chip-select by one cycle after the address strobe. One bit adds a setup cycle between chip-select and the strobe. One bit adds a hold cycle between the strobe and chip-select release. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the sequencer is idle or in the done cycle of the current access. A request taken in the done cycle for the same area, with the delay bit clear for both accesses, keeps chip-select low and skips the setup and hold cycles. Any other back-to-back request first releases the current chip-select. Settings are written through a small write port and are sampled when an access is accepted.

Top module: `xbus_cs_sequencer`

## Requirements
- R1: During and right after reset, all `cs_n` and `dack_n` bits, `as_n`, `rd_n` and `wr_n` are high, `done` is low and `req_ready` is high.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle state and in the done cycle. A request presented in any other cycle changes no output.
- R3: The cycle after acceptance is the address cycle. `as_n` is low for exactly that one cycle. With the delay bit (cfg bit 2) clear, the area's `cs_n` line is low in that same cycle.
- R4: With the delay bit set, `cs_n` stays high in the address cycle and goes low in the next cycle. Exactly one setup cycle then follows before the strobe, whatever the setup bit says.
- R5: For a fresh access with the delay bit clear, the strobe comes in the cycle right after the address cycle when the setup bit (cfg bit 1) is clear. When the setup bit is set, the strobe comes one cycle later.
- R6: The strobe lasts one cycle, with chip-select low. It is on `rd_n` when `req_write` was 0 and on `wr_n` when `req_write` was 1. The two strobes are never low together.
- R7: `done` is high for exactly the one cycle after the strobe, and chip-select is still low in that cycle.
- R8: When no continuation follows, `cs_n` returns high in the cycle after the done cycle if the hold bit (cfg bit 0) is clear. If the hold bit is set, `cs_n` stays low one cycle longer and `req_ready` is low in that cycle.
- R9: A request accepted in the done cycle for the same area, with the delay bit clear in both the current and the new setting, keeps `cs_n` low throughout. Its address cycle follows the done cycle at once, and its strobe follows the address cycle directly, with no setup and no hold cycle.
- R10: Any other back-to-back request applies the current area's hold setting before the new access starts. For the same area, at least one cycle with all `cs_n` high separates the two accesses.
- R11: Each `dack_n` bit equals the `cs_n` bit of the same area in every cycle.
- R12: A settings write (`cfg_we`, `cfg_area`, `cfg_bits`) takes effect for requests accepted in later cycles. An access already accepted keeps the setting it sampled.
- R13: At most one `cs_n` bit is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for one area's timing setting |
| cfg_area | input | 2 | Area whose setting is written |
| cfg_bits | input | 3 | Setting value: bit 2 delay, bit 1 setup, bit 0 hold |
| req_valid | input | 1 | Access request present |
| req_area | input | 2 | Chip-select area of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Request can be taken this cycle |
| cs_n | output | 4 | Chip-select lines, one per area, active low |
| dack_n | output | 4 | DMA-acknowledge lines mirroring chip-select, active low |
| as_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
All outputs are decoded directly from registered state. A wrong state therefore shows at the ports in the very cycle it exists, as a chip-select edge one cycle early or late, a missing or extra setup or hold cycle, or a done pulse out of place. A wrongly captured setting or a broken continuation decision becomes visible at the next address cycle, either as chip-select staying low where a gap is required or as a skipped or doubled setup cycle. The reference model therefore compares every output on every cycle rather than only at access ends.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

    // Per-area timing setting, bit 2 = delay, bit 1 = setup, bit 0 = hold
    typedef struct packed {
        logic dly;
        logic setup;
        logic hold;
    } area_cfg_t;

    localparam int CFG_W = $bits(area_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CSON  = 3'd2,
        ST_SETUP = 3'd3,
        ST_STRB  = 3'd4,
        ST_DONE  = 3'd5,
        ST_HOLD  = 3'd6,
        ST_GAP   = 3'd7
    } seq_state_e;

endpackage

// File: rtl/xcs_cfg_bank.sv
module xcs_cfg_bank
    import xcs_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AREA_W-1:0] wr_idx,
    input  area_cfg_t         wr_cfg,
    input  logic [AREA_W-1:0] rd_idx,
    output area_cfg_t         rd_cfg
);

    area_cfg_t mem_d [N_AREAS];
    area_cfg_t mem_q [N_AREAS];

    always_comb begin
        for (int i = 0; i < N_AREAS; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_idx == AREA_W'(i))) begin
                mem_d[i] = wr_cfg;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_AREAS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_AREAS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_cfg = mem_q[rd_idx];

    // R12: a written setting is what the entry holds one cycle later
    p_cfg_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_cfg)));

endmodule

// File: rtl/xcs_seq.sv
module xcs_seq
    import xcs_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  area_cfg_t         req_cfg,
    output logic              req_ready,
    output seq_state_e        state,
    output logic [AREA_W-1:0] cur_area,
    output logic              cur_write,
    output area_cfg_t         cur_cfg
);

    typedef struct packed {
        seq_state_e        st;
        logic [AREA_W-1:0] area;
        logic              write;
        area_cfg_t         cfg;
        logic              cont;
        logic              pv;
        logic [AREA_W-1:0] parea;
        logic              pwrite;
        area_cfg_t         pcfg;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      accept;
    logic      same_req;
    logic      same_pend;
    logic      may_chain;

    assign req_ready = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);
    assign accept    = req_valid && req_ready;
    assign same_req  = (req_area == r_q.area);
    assign same_pend = (r_q.parea == r_q.area);
    assign may_chain = same_req && !r_q.cfg.dly && !req_cfg.dly;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st    = ST_ADDR;
                    r_d.area  = req_area;
                    r_d.write = req_write;
                    r_d.cfg   = req_cfg;
                    r_d.cont  = 1'b0;
                end
            end
            ST_ADDR: begin
                if (r_q.cfg.dly) begin
                    r_d.st = ST_CSON;
                end else if (r_q.cont) begin
                    r_d.st = ST_STRB;
                end else if (r_q.cfg.setup) begin
                    r_d.st = ST_SETUP;
                end else begin
                    r_d.st = ST_STRB;
                end
            end
            ST_CSON:  r_d.st = ST_SETUP;
            ST_SETUP: r_d.st = ST_STRB;
            ST_STRB:  r_d.st = ST_DONE;
            ST_DONE: begin
                if (accept) begin
                    if (may_chain) begin
                        r_d.st    = ST_ADDR;
                        r_d.area  = req_area;
                        r_d.write = req_write;
                        r_d.cfg   = req_cfg;
                        r_d.cont  = 1'b1;
                    end else begin
                        r_d.pv     = 1'b1;
                        r_d.parea  = req_area;
                        r_d.pwrite = req_write;
                        r_d.pcfg   = req_cfg;
                        if (r_q.cfg.hold) begin
                            r_d.st = ST_HOLD;
                        end else if (same_req && !req_cfg.dly) begin
                            r_d.st = ST_GAP;
                        end else begin
                            r_d.st    = ST_ADDR;
                            r_d.area  = req_area;
                            r_d.write = req_write;
                            r_d.cfg   = req_cfg;
                            r_d.cont  = 1'b0;
                            r_d.pv    = 1'b0;
                        end
                    end
                end else begin
                    r_d.pv = 1'b0;
                    r_d.st = r_q.cfg.hold ? ST_HOLD : ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!r_q.pv) begin
                    r_d.st = ST_IDLE;
                end else if (same_pend && !r_q.pcfg.dly) begin
                    r_d.st = ST_GAP;
                end else begin
                    r_d.st    = ST_ADDR;
                    r_d.area  = r_q.parea;
                    r_d.write = r_q.pwrite;
                    r_d.cfg   = r_q.pcfg;
                    r_d.cont  = 1'b0;
                    r_d.pv    = 1'b0;
                end
            end
            ST_GAP: begin
                r_d.st    = ST_ADDR;
                r_d.area  = r_q.parea;
                r_d.write = r_q.pwrite;
                r_d.cfg   = r_q.pcfg;
                r_d.cont  = 1'b0;
                r_d.pv    = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign cur_area  = r_q.area;
    assign cur_write = r_q.write;
    assign cur_cfg   = r_q.cfg;

    // R3: the address cycle never repeats back to back
    p_addr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR) |=> (r_q.st != ST_ADDR));

    // R4: delayed chip-select is always followed by one setup cycle
    p_dly_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CSON) |=> (r_q.st == ST_SETUP));

    // R9: a continued access goes straight from address to strobe
    p_chain_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR && r_q.cont) |=> (r_q.st == ST_STRB));

    // R2: nothing is accepted outside idle or done
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STRB) |=> $stable(r_q.area));

endmodule

// File: rtl/xcs_out_decode.sv
module xcs_out_decode
    import xcs_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_e         state,
    input  logic [AREA_W-1:0]  area,
    input  logic               write,
    input  area_cfg_t          cfg,
    output logic [N_AREAS-1:0] cs_n,
    output logic [N_AREAS-1:0] dack_n,
    output logic               as_n,
    output logic               rd_n,
    output logic               wr_n,
    output logic               done
);

    logic cs_on;
    logic strobe;

    always_comb begin
        unique case (state)
            ST_ADDR:                          cs_on = !cfg.dly;
            ST_CSON, ST_SETUP, ST_STRB,
            ST_DONE, ST_HOLD:                 cs_on = 1'b1;
            default:                          cs_on = 1'b0;
        endcase
    end

    assign strobe = (state == ST_STRB);
    assign as_n   = (state != ST_ADDR);
    assign rd_n   = !(strobe && !write);
    assign wr_n   = !(strobe && write);
    assign done   = (state == ST_DONE);

    for (genvar g = 0; g < N_AREAS; g++) begin : g_line
        assign cs_n[g]   = !(cs_on && (area == AREA_W'(g)));
        assign dack_n[g] = !(cs_on && (area == AREA_W'(g)));
    end

    // R13: never two areas selected
    p_one_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6: strobes are exclusive and last one cycle
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |=> (rd_n && wr_n));
    p_strobe_under_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (cs_n != '1));

    // R7: done follows the strobe and chip-select is still held
    p_done_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |=> (done && (cs_n != '1)));

endmodule

// File: rtl/xbus_cs_sequencer.sv
module xbus_cs_sequencer
    import xcs_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [AREA_W-1:0]  cfg_area,
    input  logic [CFG_W-1:0]   cfg_bits,
    input  logic               req_valid,
    input  logic [AREA_W-1:0]  req_area,
    input  logic               req_write,
    output logic               req_ready,
    output logic [N_AREAS-1:0] cs_n,
    output logic [N_AREAS-1:0] dack_n,
    output logic               as_n,
    output logic               rd_n,
    output logic               wr_n,
    output logic               done
);

    area_cfg_t         req_cfg;
    seq_state_e        state;
    logic [AREA_W-1:0] cur_area;
    logic              cur_write;
    area_cfg_t         cur_cfg;

    xcs_cfg_bank #(.N_AREAS(N_AREAS), .AREA_W(AREA_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_area),
        .wr_cfg (area_cfg_t'(cfg_bits)),
        .rd_idx (req_area),
        .rd_cfg (req_cfg)
    );

    xcs_seq #(.N_AREAS(N_AREAS), .AREA_W(AREA_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_area  (req_area),
        .req_write (req_write),
        .req_cfg   (req_cfg),
        .req_ready (req_ready),
        .state     (state),
        .cur_area  (cur_area),
        .cur_write (cur_write),
        .cur_cfg   (cur_cfg)
    );

    xcs_out_decode #(.N_AREAS(N_AREAS), .AREA_W(AREA_W)) i_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .area   (cur_area),
        .write  (cur_write),
        .cfg    (cur_cfg),
        .cs_n   (cs_n),
        .dack_n (dack_n),
        .as_n   (as_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .done   (done)
    );

    // R2: the done cycle always offers acceptance
    p_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

// File: tb/test_xbus_cs_sequencer.sv
module test_xbus_cs_sequencer;

    localparam int NA = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_area = '0;
    logic [2:0] cfg_bits = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_area = '0;
    logic       req_write = 1'b0;
    logic       req_ready;
    logic [3:0] cs_n;
    logic [3:0] dack_n;
    logic       as_n, rd_n, wr_n, done;

    always #5 clk = ~clk;

    xbus_cs_sequencer i_xbus_cs_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
        .cfg_bits(cfg_bits), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_ready(req_ready), .cs_n(cs_n),
        .dack_n(dack_n), .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
    );

    typedef struct {
        bit       v;
        int       ra;
        bit       rw;
        bit       we;
        int       wa;
        bit [2:0] wb;
        bit [3:0] cs;
        bit       as_n;
        bit       rd_n;
        bit       wr_n;
        bit       dn;
        bit       rdy;
        string    tag;
    } cyc_t;

    cyc_t     sched[$];
    bit [2:0] mcfg[NA];
    bit       open_q;
    int       cur_area;
    bit [2:0] cur_cfg;
    int       compared;
    int       mismatched;
    bit       finished;

    function automatic cyc_t mk(string tag);
        cyc_t c;
        c.v = 0; c.ra = 0; c.rw = 0; c.we = 0; c.wa = 0; c.wb = 0;
        c.cs = 4'hF; c.as_n = 1; c.rd_n = 1; c.wr_n = 1; c.dn = 0; c.rdy = 0;
        c.tag = tag;
        return c;
    endfunction

    function automatic bit [3:0] csv(int a);
        return ~(4'b0001 << a);
    endfunction

    task automatic close_acc();
        cyc_t c;
        if (open_q) begin
            c = mk("R7"); c.cs = csv(cur_area); c.dn = 1; c.rdy = 1;
            sched.push_back(c);
            if (cur_cfg[0]) begin
                c = mk("R8"); c.cs = csv(cur_area);
                sched.push_back(c);
            end
            open_q = 0;
        end
    endtask

    task automatic idle(int n);
        cyc_t c;
        close_acc();
        for (int i = 0; i < n; i++) begin
            c = mk("R2"); c.rdy = 1;
            sched.push_back(c);
        end
    endtask

    task automatic wcfg(int a, bit [2:0] bits);
        cyc_t c;
        close_acc();
        c = mk("R12"); c.rdy = 1; c.we = 1; c.wa = a; c.wb = bits;
        sched.push_back(c);
        mcfg[a] = bits;
    endtask

    task automatic body(int a, bit wr, bit [2:0] cf, bit cont, bit junk,
                        bit midw, bit [2:0] midbits, string tag);
        cyc_t c;
        c = mk(tag); c.as_n = 0;
        if (!cf[2]) c.cs = csv(a);
        if (junk) begin c.v = 1; c.ra = (a + 1) % NA; c.rw = !wr; end
        if (midw) begin c.we = 1; c.wa = a; c.wb = midbits; end
        sched.push_back(c);
        if (midw) mcfg[a] = midbits;
        if (cf[2]) begin
            c = mk(tag); c.cs = csv(a);
            if (junk) begin c.v = 1; c.ra = (a + 2) % NA; c.rw = wr; end
            sched.push_back(c);
        end
        if (cf[2] || (cf[1] && !cont)) begin
            c = mk(tag); c.cs = csv(a);
            if (junk) begin c.v = 1; c.ra = (a + 3) % NA; c.rw = wr; end
            sched.push_back(c);
        end
        c = mk(tag); c.cs = csv(a); c.rd_n = wr; c.wr_n = !wr;
        if (junk) begin c.v = 1; c.ra = (a + 1) % NA; c.rw = wr; end
        sched.push_back(c);
        open_q = 1; cur_area = a; cur_cfg = cf;
    endtask

    task automatic access(int a, bit wr, bit b2b, bit junk, bit midw,
                          bit [2:0] midbits, string tag);
        cyc_t     c;
        bit [2:0] nc;
        bit       same, cont;
        nc = mcfg[a];
        if (b2b && open_q) begin
            c = mk("R7"); c.cs = csv(cur_area); c.dn = 1; c.rdy = 1;
            c.v = 1; c.ra = a; c.rw = wr;
            sched.push_back(c);
            same = (a == cur_area);
            cont = same && !cur_cfg[2] && !nc[2];
            if (!cont) begin
                if (cur_cfg[0]) begin
                    c = mk("R8"); c.cs = csv(cur_area);
                    sched.push_back(c);
                end
                if (same && !nc[2]) begin
                    c = mk("R10");
                    sched.push_back(c);
                end
            end
            open_q = 0;
            body(a, wr, nc, cont, junk, midw, midbits, tag);
        end else begin
            close_acc();
            c = mk("R2"); c.rdy = 1; c.v = 1; c.ra = a; c.rw = wr;
            sched.push_back(c);
            body(a, wr, nc, 1'b0, junk, midw, midbits, tag);
        end
    endtask

    task automatic check_now(cyc_t e, int k);
        logic [8:0] act, exp;
        act = {cs_n, as_n, rd_n, wr_n, done, req_ready};
        exp = {e.cs, e.as_n, e.rd_n, e.wr_n, e.dn, e.rdy};
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d: {cs_n,as_n,rd_n,wr_n,done,ready} actual %b expected %b",
                     e.tag, k, act, exp);
        end
        compared++;
        if (dack_n !== e.cs) begin
            mismatched++;
            $display("FAIL R11 cycle %0d: dack_n actual %b expected %b", k, dack_n, e.cs);
        end
    endtask

    task automatic drive(cyc_t c);
        req_valid = c.v;
        req_area  = 2'(c.ra);
        req_write = c.rw;
        cfg_we    = c.we;
        cfg_area  = 2'(c.wa);
        cfg_bits  = c.wb;
    endtask

    initial begin
        cyc_t r;
        for (int i = 0; i < NA; i++) mcfg[i] = 3'b000;
        open_q = 0;
        // settings: bit2 delay, bit1 setup, bit0 hold
        wcfg(0, 3'b000);
        wcfg(1, 3'b010);
        wcfg(2, 3'b100);
        wcfg(3, 3'b001);
        idle(2);
        access(0, 0, 0, 0, 0, 3'b0, "R3");   // fresh, no delay
        access(0, 1, 1, 0, 0, 3'b0, "R9");   // continuation
        access(1, 0, 1, 0, 0, 3'b0, "R5");   // other area, setup cycle
        access(1, 1, 1, 0, 0, 3'b0, "R9");   // continuation skips setup
        access(3, 0, 1, 0, 0, 3'b0, "R10");  // other area
        access(3, 1, 1, 0, 0, 3'b0, "R9");   // continuation skips hold
        access(2, 0, 1, 0, 0, 3'b0, "R4");   // after hold, delayed area
        access(2, 1, 1, 0, 0, 3'b0, "R10");  // same area, delay forces gap
        idle(1);
        access(1, 0, 0, 1, 0, 3'b0, "R2");   // junk requests while busy
        access(3, 1, 0, 0, 0, 3'b0, "R8");   // hold on close
        wcfg(2, 3'b110);
        access(2, 0, 0, 0, 0, 3'b0, "R4");   // delay with setup bit: one setup
        access(2, 1, 1, 0, 1, 3'b000, "R12"); // mid-access write ignored here
        access(2, 0, 1, 0, 0, 3'b0, "R10");  // same area after delay cleared
        access(0, 1, 1, 0, 0, 3'b0, "R6");   // write strobe, other area
        access(1, 0, 0, 0, 0, 3'b0, "R5");   // fresh with setup
        idle(3);

        rst_n = 0;
        r = mk("R1"); r.rdy = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_now(r, -1);
        end
        @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < sched.size(); k++) begin
            check_now(sched[k], k);
            drive(sched[k]);
            @(negedge clk);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            mismatched++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule